// File: doc/BRIEF.md
# Nine-Bit Serial Transmitter with Diagnostic Loopback

This block is the transmit half of an asynchronous serial port. Software-side logic writes a character into a one-entry holding buffer. When the shifter is free, the character moves into a shift register and goes out least significant bit first. Each frame has a low start bit, seven, eight or nine data bits, and a high stop period. The ninth data bit does not come from the written word: it is taken from a separate control input when the frame is loaded. This lets an address or data marker travel with each character.

Bit timing comes from an oversampling strobe, `os_tick`, that pulses sixteen times per bit period. The strobe is generated elsewhere. A data bit lasts sixteen strobes. The stop period lasts fourteen, sixteen or thirty-two strobes.

Setting both character-length bits selects a diagnostic loopback. In loopback:
- the frame is fixed at nine data bits;
- the shifter output drives the receive-side serial input `rx_sd` in place of the pin `rx_pin`;
- the external line `txd` is held high.

A reinitialisation input, used on entry to a low-power state, does the following:
- aborts any frame in progress;
- fills the shift register with ones;
- marks the buffer empty without changing its contents.

Top module: `ser9_tx`

## Requirements
- R1: While reset is active and after it is released, `txd` is high, `tx_empty` is 1 and `rx_sd` follows `rx_pin`.
- R2: A write sets the buffer occupied, so `tx_empty` reads 0 from the next cycle. The buffered character moves into the shifter only when the shifter is idle or finishing its stop period. At that move `tx_empty` returns to 1 and the start bit appears on the following cycle.
- R3: A frame is a start bit at 0, followed by the data bits least significant first. Each bit lasts exactly 16 `os_tick` strobes.
- R4: `char_len` encodings are: 2'b10 gives 7 data bits (`wr_data[6:0]`), 2'b00 gives 8 data bits, and 2'b01 gives 9 data bits. In the 9-bit mode the ninth bit is `bit9_ctl`, sampled when the character moves into the shifter.
- R5: `stop_sel` encodings are: 2'b00 and 2'b11 give 16 strobes of high level, 2'b01 gives 32, and 2'b10 gives 14. Back-to-back frames are separated by exactly that many strobes.
- R6: With `char_len` = 2'b11 (loopback) the frame carries 9 data bits, the ninth from `bit9_ctl`, with no parity bit. `rx_sd` carries the shifter output regardless of `rx_pin`, and `txd` stays 1.
- R7: A cycle with `reinit` at 1 has these effects from the next cycle: `tx_empty` is 1, every shifter bit is 1 (line high), and the frame in progress is dropped. A write in the same cycle is ignored, and the buffered character is kept but not sent.
- R8: Without an `os_tick` strobe the line holds its level: no bit, start or stop period advances.
- R9: A write while the buffer is occupied replaces the buffered character, so only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | Oversampling strobe, 16 per bit period |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to write |
| bit9_ctl | input | 1 | Value of the ninth data bit |
| char_len | input | 2 | Character length; 2'b11 selects loopback |
| stop_sel | input | 2 | Stop-period length select |
| reinit | input | 1 | Low-power reinitialisation |
| rx_pin | input | 1 | External receive line |
| tx_empty | output | 1 | Holding buffer empty flag |
| txd | output | 1 | External transmit line |
| rx_sd | output | 1 | Serial input handed to the receiver |

## Verification
The checker watches four things on every cycle:
- In loopback, the pin stays high and the receive path mirrors the shifter.
- After a reinit cycle, the buffer is empty, the shifter is all ones and the buffered character is unchanged.
- A write makes the buffer occupied, a load always puts a start bit on the line, and the idle line is high.
- The shifter does not move without a strobe.

Only the bench scenarios can show the rest:
- the bit order and length of whole frames;
- the exact stop durations between back-to-back characters;
- the overwrite of a buffered character;
- an aborted frame that never resumes.

The bench checks these by decoding every frame in strobe counts, across all 256 character values and across every mode and stop combination.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } seq_state_t;

  // character length codes
  localparam logic [1:0] CL_8    = 2'b00;
  localparam logic [1:0] CL_9    = 2'b01;
  localparam logic [1:0] CL_7    = 2'b10;
  localparam logic [1:0] CL_LOOP = 2'b11;

  // stop period codes (2'b11 behaves as one stop bit)
  localparam logic [1:0] SP_ONE  = 2'b00;
  localparam logic [1:0] SP_TWO  = 2'b01;
  localparam logic [1:0] SP_FRAC = 2'b10;

endpackage

// File: rtl/ser9_rst_sync.sv
module ser9_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/ser9_hold_buf.sv
module ser9_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              reinit,
  output logic [DATA_W-1:0] buf_q,
  output logic              full_q
);

  logic [DATA_W-1:0] buf_n;
  logic              full_n;
  logic              buf_en;

  // reinit wins over a write in the same cycle; data is always retained
  always_comb begin
    buf_en = wr_en | load | reinit;
    buf_n  = buf_q;
    full_n = full_q;
    if (reinit) begin
      full_n = 1'b0;
    end else if (wr_en) begin
      buf_n  = wr_data;
      full_n = 1'b1;
    end else if (load) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
    end else if (buf_en) begin
      buf_q  <= buf_n;
      full_q <= full_n;
    end
  end

endmodule

// File: rtl/ser9_shifter.sv
module ser9_shifter #(
  parameter int DATA_W = 8,
  parameter int SFT_W  = DATA_W + 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              reinit,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  input  logic [CNT_W-1:0]  ndata,
  output logic [SFT_W-1:0]  sft_q
);

  logic [SFT_W-1:0]  load_word;
  logic [SFT_W-1:0]  sft_n;
  logic [DATA_W:0]   src;
  logic              sft_en;

  assign src          = {bit9, data};
  assign load_word[0] = 1'b0;

  // data positions beyond the selected length are filled with stop level
  for (genvar gi = 0; gi <= DATA_W; gi++) begin : g_fill
    assign load_word[gi+1] = (CNT_W'(gi) < ndata) ? src[gi] : 1'b1;
  end

  always_comb begin
    sft_en = reinit | load | shift;
    if (reinit)    sft_n = '1;
    else if (load) sft_n = load_word;
    else           sft_n = {1'b1, sft_q[SFT_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sft_q <= '1;
    else if (sft_en) sft_q <= sft_n;
  end

endmodule

// File: rtl/ser9_seq.sv
module ser9_seq
  import ser9_pkg::*;
#(
  parameter int OS_RATE    = 16,
  parameter int FRAC_TICKS = 14,
  parameter int CNT_W      = 4,
  parameter int TICK_W     = $clog2(OS_RATE),
  parameter int STOP_W     = $clog2(2 * OS_RATE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             buf_full,
  input  logic             reinit,
  input  logic [1:0]       stop_sel,
  input  logic [CNT_W-1:0] ndata,
  output logic             load,
  output logic             shift,
  output logic             idle
);

  seq_state_t        st_q, st_n;
  logic [TICK_W-1:0] tick_q, tick_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [STOP_W-1:0] stop_q, stop_n;
  logic [STOP_W-1:0] stop_len;
  logic              bit_end, stop_done, seq_en;

  always_comb begin
    case (stop_sel)
      SP_TWO:  stop_len = STOP_W'(2 * OS_RATE);
      SP_FRAC: stop_len = STOP_W'(FRAC_TICKS);
      default: stop_len = STOP_W'(OS_RATE);
    endcase
    bit_end   = (st_q == ST_DATA) && os_tick && (tick_q == TICK_W'(OS_RATE - 1));
    stop_done = (st_q == ST_STOP) && os_tick && (stop_q == stop_len - 1'b1);
    load      = buf_full && !reinit && ((st_q == ST_IDLE) || stop_done);
    shift     = bit_end && !reinit;
    seq_en    = os_tick | load | reinit;

    st_n   = st_q;
    tick_n = tick_q;
    left_n = left_q;
    stop_n = stop_q;
    case (st_q)
      ST_DATA: if (os_tick) begin
        tick_n = tick_q + 1'b1;
        if (bit_end) begin
          left_n = left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            st_n   = ST_STOP;
            stop_n = '0;
          end
        end
      end
      ST_STOP: if (os_tick) begin
        stop_n = stop_q + 1'b1;
        if (stop_done) st_n = ST_IDLE;
      end
      default: ;
    endcase
    if (load) begin
      st_n   = ST_DATA;
      tick_n = '0;
      left_n = ndata + CNT_W'(1);
    end
    if (reinit) begin
      st_n   = ST_IDLE;
      tick_n = '0;
      left_n = '0;
      stop_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tick_q <= '0;
      left_q <= '0;
      stop_q <= '0;
    end else if (seq_en) begin
      st_q   <= st_n;
      tick_q <= tick_n;
      left_q <= left_n;
      stop_q <= stop_n;
    end
  end

  assign idle = (st_q == ST_IDLE);

endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
  import ser9_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OS_RATE    = 16,
  parameter int FRAC_TICKS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9_ctl,
  input  logic [1:0]        char_len,
  input  logic [1:0]        stop_sel,
  input  logic              reinit,
  input  logic              rx_pin,
  output logic              tx_empty,
  output logic              txd,
  output logic              rx_sd
);

  localparam int SFT_W = DATA_W + 2;
  localparam int CNT_W = $clog2(SFT_W + 1);

  logic              rst_s_n;
  logic              load, shift, seq_idle, buf_full, loop_on;
  logic [DATA_W-1:0] buf_q;
  logic [SFT_W-1:0]  sft_word;
  logic [CNT_W-1:0]  ndata;

  ser9_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_s_n (rst_s_n)
  );

  // loopback forces the nine-bit frame
  always_comb begin
    case (char_len)
      CL_7:    ndata = CNT_W'(DATA_W - 1);
      CL_8:    ndata = CNT_W'(DATA_W);
      default: ndata = CNT_W'(DATA_W + 1);
    endcase
  end

  ser9_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .load    (load),
    .reinit  (reinit),
    .buf_q   (buf_q),
    .full_q  (buf_full)
  );

  ser9_seq #(
    .OS_RATE    (OS_RATE),
    .FRAC_TICKS (FRAC_TICKS),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .os_tick  (os_tick),
    .buf_full (buf_full),
    .reinit   (reinit),
    .stop_sel (stop_sel),
    .ndata    (ndata),
    .load     (load),
    .shift    (shift),
    .idle     (seq_idle)
  );

  ser9_shifter #(
    .DATA_W (DATA_W),
    .SFT_W  (SFT_W),
    .CNT_W  (CNT_W)
  ) u_sft (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load   (load),
    .shift  (shift),
    .reinit (reinit),
    .data   (buf_q),
    .bit9   (bit9_ctl),
    .ndata  (ndata),
    .sft_q  (sft_word)
  );

  assign loop_on  = (char_len == CL_LOOP);
  assign tx_empty = ~buf_full;
  assign txd      = loop_on | sft_word[0];
  assign rx_sd    = loop_on ? sft_word[0] : rx_pin;

endmodule

// File: rtl/ser9_tx_chk.sv
module ser9_tx_chk #(
  parameter int DATA_W = 8,
  parameter int SFT_W  = DATA_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              os_tick,
  input logic              wr_en,
  input logic              reinit,
  input logic [1:0]        char_len,
  input logic              txd,
  input logic              rx_sd,
  input logic              tx_empty,
  input logic              load,
  input logic              idle,
  input logic [SFT_W-1:0]  sft_word,
  input logic [DATA_W-1:0] buf_q
);

  assert_loop_pin_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_len == 2'b11) |-> txd);

  assert_loop_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_len == 2'b11) |-> (rx_sd == sft_word[0]));

  assert_reinit_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (tx_empty && (&sft_word)));

  assert_reinit_keeps_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (buf_q == $past(buf_q)));

  assert_write_occupies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reinit) |=> !tx_empty);

  assert_load_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !sft_word[0]);

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> sft_word[0]);

  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_tick && !reinit && !load) |=> $stable(sft_word));

endmodule

bind ser9_tx ser9_tx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .os_tick  (os_tick),
  .wr_en    (wr_en),
  .reinit   (reinit),
  .char_len (char_len),
  .txd      (txd),
  .rx_sd    (rx_sd),
  .tx_empty (tx_empty),
  .load     (load),
  .idle     (seq_idle),
  .sft_word (sft_word),
  .buf_q    (buf_q)
);

// File: tb/test_ser9_tx.sv
`timescale 1ns/1ps
module test_ser9_tx;

  localparam int OSR = 16;

  logic       clk = 1'b0;
  logic       rst_n, os_tick, wr_en, bit9_ctl, reinit, rx_pin;
  logic [7:0] wr_data;
  logic [1:0] char_len, stop_sel;
  logic       tx_empty, txd, rx_sd;

  int n_chk = 0, n_fail = 0;
  int tck = 0;
  int tick_div = 1, tdc = 0;
  bit tick_on = 1'b1;
  int nxt_t0;
  bit have_start = 1'b0;
  logic [7:0] vals [256];
  logic       b9s  [256];

  always #2 clk = ~clk;

  ser9_tx i_ser9_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en), .wr_data(wr_data),
    .bit9_ctl(bit9_ctl), .char_len(char_len), .stop_sel(stop_sel), .reinit(reinit),
    .rx_pin(rx_pin), .tx_empty(tx_empty), .txd(txd), .rx_sd(rx_sd)
  );

  always @(negedge clk) begin
    if (tdc + 1 >= tick_div) tdc = 0;
    else tdc = tdc + 1;
    os_tick = tick_on && (tdc == 0);
  end

  always @(posedge clk) if (os_tick === 1'b1) tck <= tck + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic line(input bit use_rx);
    return use_rx ? rx_sd : txd;
  endfunction

  function automatic int stop_ticks(input logic [1:0] sp);
    case (sp)
      2'b01:   return 2 * OSR;
      2'b10:   return 14;
      default: return OSR;
    endcase
  endfunction

  function automatic int nbits(input logic [1:0] cl);
    case (cl)
      2'b10:   return 7;
      2'b00:   return 8;
      default: return 9;
    endcase
  endfunction

  // decode one frame in strobe counts; optionally measure the stop gap to the next start
  task automatic grab(input bit use_rx, input int nd, input logic [8:0] w,
                      input bit want_stop, input int exp_stop, input string req);
    int t0;
    if (have_start) t0 = nxt_t0;
    else begin
      while (line(use_rx) !== 1'b0) @(negedge clk);
      t0 = tck;
    end
    have_start = 1'b0;
    for (int k = 0; k <= nd; k++) begin
      while (tck - t0 < OSR * k + 8) @(negedge clk);
      if (k == 0) chk({req, " R3 start bit"}, int'(line(use_rx)), 0);
      else chk($sformatf("%s R3 data bit %0d", req, k - 1), int'(line(use_rx)), int'(w[k-1]));
      if (use_rx) chk("R6 txd high in loopback", int'(txd), 1);
    end
    if (want_stop) begin
      while (tck - t0 < OSR * (nd + 1)) @(negedge clk);
      while (line(use_rx) !== 1'b0) @(negedge clk);
      chk({req, " R5 stop length"}, tck - t0 - OSR * (nd + 1), exp_stop);
      nxt_t0 = tck;
      have_start = 1'b1;
    end
  endtask

  task automatic put(input logic [7:0] d, input logic b9);
    wr_data = d; bit9_ctl = b9; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stream(input logic [1:0] cl, input logic [1:0] sp, input int n, input string req);
    bit use_rx;
    use_rx = (cl == 2'b11);
    char_len = cl; stop_sel = sp; rx_pin = use_rx ? 1'b0 : 1'b1;
    have_start = 1'b0;
    @(negedge clk);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          while (!tx_empty) @(negedge clk);
          put(vals[i], b9s[i]);
        end
      end
      begin
        for (int i = 0; i < n; i++)
          grab(use_rx, nbits(cl), {b9s[i], vals[i]}, i < n - 1, stop_ticks(sp), req);
      end
    join
    repeat (3 * OSR * tick_div + 4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit stay;
    logic v;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; bit9_ctl = 1'b0; reinit = 1'b0;
    char_len = 2'b00; stop_sel = 2'b00; rx_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 txd in reset", int'(txd), 1);
    chk("R1 tx_empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 txd after reset", int'(txd), 1);
    chk("R1 tx_empty after reset", int'(tx_empty), 1);
    rx_pin = 1'b0; #1;
    chk("R1 rx_sd follows pin 0", int'(rx_sd), 0);
    rx_pin = 1'b1; #1;
    chk("R1 rx_sd follows pin 1", int'(rx_sd), 1);
    char_len = 2'b11; rx_pin = 1'b0; #1;
    chk("R6 idle loopback rx_sd from shifter", int'(rx_sd), 1);
    chk("R6 idle loopback txd", int'(txd), 1);
    char_len = 2'b00; rx_pin = 1'b1;
    @(negedge clk);

    // R2: write timing and load gating
    fork
      begin
        grab(0, 8, {1'b0, 8'h96}, 1, OSR, "R2 first");
        grab(0, 8, {1'b0, 8'h3B}, 0, 0, "R2 second");
      end
      begin
        put(8'h96, 1'b0);
        chk("R2 tx_empty after write", int'(tx_empty), 0);
        @(negedge clk);
        chk("R2 tx_empty after load", int'(tx_empty), 1);
        chk("R2 start after load", int'(txd), 0);
        repeat (5) @(negedge clk);
        put(8'h3B, 1'b0);
        repeat (100) @(negedge clk);
        chk("R2 held while shifter busy", int'(tx_empty), 0);
      end
    join
    repeat (3 * OSR) @(negedge clk);

    // R9: last write wins
    fork
      begin
        grab(0, 8, {1'b0, 8'h11}, 1, OSR, "R9 first");
        grab(0, 8, {1'b0, 8'hC7}, 0, 0, "R9 replaced");
      end
      begin
        put(8'h11, 1'b0);
        repeat (20) @(negedge clk);
        put(8'h22, 1'b0);
        put(8'hC7, 1'b0);
      end
    join
    repeat (3 * OSR) @(negedge clk);

    // R4 R5 R6: every length and stop code
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'h5A;
    b9s[0] = 1'b1; b9s[1] = 1'b0; b9s[2] = 1'b1; b9s[3] = 1'b0;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++)
        stream(2'(c), 2'(s), 4, $sformatf("R4 R5 len%0d stop%0d", c, s));

    // R4 R5: all character values, nine bits, 7/8 stop
    for (int i = 0; i < 256; i++) begin
      vals[i] = 8'(i);
      b9s[i]  = ^8'(i);
    end
    stream(2'b01, 2'b10, 256, "R4 sweep");

    // R8: sparse strobes, and a freeze with no strobes
    tick_div = 3;
    vals[0] = 8'h0F; vals[1] = 8'hE1; b9s[0] = 1'b0; b9s[1] = 1'b1;
    stream(2'b00, 2'b00, 2, "R8 sparse");
    tick_div = 1;
    char_len = 2'b00;
    fork
      grab(0, 8, {1'b0, 8'h0F}, 0, 0, "R8 freeze");
      begin
        int t;
        put(8'h0F, 1'b0);
        t = tck;
        while (tck < t + 53) @(negedge clk);
        tick_on = 1'b0;
        @(negedge clk);
        v = txd; stay = 1'b1;
        repeat (60) begin
          @(negedge clk);
          if (txd !== v) stay = 1'b0;
        end
        chk("R8 line holds without strobes", int'(stay), 1);
        tick_on = 1'b1;
      end
    join
    repeat (3 * OSR) @(negedge clk);

    // R7: reinit mid-frame with a concurrent write
    put(8'h00, 1'b0);
    repeat (3) @(negedge clk);
    put(8'h00, 1'b0);
    repeat (40) @(negedge clk);
    chk("R7 line low before reinit", int'(txd), 0);
    reinit = 1'b1; wr_en = 1'b1; wr_data = 8'hAA;
    @(negedge clk);
    reinit = 1'b0; wr_en = 1'b0;
    chk("R7 txd high after reinit", int'(txd), 1);
    chk("R7 tx_empty after reinit", int'(tx_empty), 1);
    stay = 1'b1;
    repeat (400) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_empty !== 1'b1) stay = 1'b0;
    end
    chk("R7 frame dropped and write ignored", int'(stay), 1);
    fork
      grab(0, 8, {1'b0, 8'h3C}, 0, 0, "R7 recovery");
      put(8'h3C, 1'b0);
    join
    repeat (3 * OSR) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule